// File: doc/BRIEF.md
# Cascaded second-level interrupt aggregator

This block gathers level-sensitive interrupt requests from up to 32 peripheral sources per register pair and folds them onto a small number of interrupt lines that feed a parent controller. Each parent output has its own map mask. An output goes high when any source selected by that mask is both pending and enabled. Software controls the enable bits through a small memory-mapped register window. Each window has one enable word and one read-only status word.

Some sources, typically serial ports, have a forward path. When the forward mask selects such a source, it skips the enable and map logic entirely. It then drives its own dedicated parent line directly, so the parent sees it as if it were wired straight through. Map masks, forward masks and the set of wired bit positions are elaboration parameters. Bit positions that no source is wired to are ignored everywhere. The number of enable/status pairs is a parameter. Pair `p` occupies bytes `8p..8p+7` of the address space.

Top module: `l2_irq_aggregator`

## Requirements
- R1: After reset, every enable word reads 0x0000_0000 and every aggregated output is low.
- R2: A write to byte offset 0x0 of pair `p` (address `8p`) replaces the whole enable word of that pair with the written data. There is no bitwise set or clear. Bits at unwired positions store and read back as 0. When no write occurs, the enable word holds its value.
- R3: Byte offset 0x4 of pair `p` (address `8p+4`) returns the live input level of the pair's wired sources, with unwired bits reading 0. Writes to this offset change nothing.
- R4: Aggregated output `o` is high in the cycle after a clock edge when, at that edge, a source is high that is selected by output `o`'s map mask, enabled, and not forwarded. One register stage separates the inputs from the output.
- R5: A source whose enable bit is 0 never raises an aggregated output.
- R6: A source whose forward bit is 1 drives its own dedicated line `fwd_irq[i]` combinationally, whatever its enable bit. Such a source never affects any aggregated output.
- R7: `fwd_irq[i]` is held low for every source `i` whose forward bit is 0, so no source shows up on both paths.
- R8: A source at an unwired position never raises an aggregated output, a forward line or a status bit.
- R9: Source `32p+k` belongs to bit `k` of pair `p`, and its map mask bits for output `o` are in map word `o*NPAIRS+p`. Sources in the second pair aggregate the same way as those in the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 32*NPAIRS | Level interrupt requests, source `32p+k` at bit `32p+k` |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte address (pair in the bits above bit 2, bit 2 picks status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | NOUT | Registered aggregated lines to the parent |
| fwd_irq | output | 32*NPAIRS | Dedicated forward lines, one per source position |

## Verification
A corrupted enable bit is visible at the ports in two ways. It reads back wrong at offset 0x0 in the same cycle. It also either swallows or invents a parent output one edge after the matching source changes. A fault in the forward selection shows up immediately as a combinational error on `fwd_irq`, and one edge later as an aggregated output that reacts to a forwarded source. Unwired positions are driven high on purpose, so that any leak into status, forward lines or outputs appears within one cycle.

// File: rtl/l2_irq_aggregator.sv
module l2_irq_aggregator #(
  parameter int NPAIRS = 2,
  parameter int NOUT   = 2,
  parameter logic [NPAIRS*32-1:0]      CONN_MASK = {32'h0000_00FF, 32'h0000_0FFF},
  parameter logic [NPAIRS*32-1:0]      FWD_MASK  = {32'h0000_0000, 32'h0000_0007},
  parameter logic [NOUT*NPAIRS*32-1:0] MAP_MASK  = {32'h0000_00F0, 32'h0000_0140,
                                                    32'h0000_000F, 32'h0000_0EB8},
  localparam int NSRC = NPAIRS * 32,
  localparam int PW   = (NPAIRS > 1) ? $clog2(NPAIRS) : 1,
  localparam int AW   = PW + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NOUT-1:0]  irq_out,
  output logic [NSRC-1:0]  fwd_irq
);

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] agg;
  logic [NOUT-1:0] irq_next;
  logic [PW-1:0]   pidx;
  logic            sel_status;

  assign pidx       = bus_addr[AW-1:3];
  assign sel_status = bus_addr[2];

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        en_q[p*32 +: 32] <= '0;
      else if (bus_we && !sel_status && (int'(pidx) == p))
        en_q[p*32 +: 32] <= bus_wdata & CONN_MASK[p*32 +: 32];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPAIRS; p++)
      if (int'(pidx) == p)
        bus_rdata = sel_status ? (src_in[p*32 +: 32] & CONN_MASK[p*32 +: 32])
                               : en_q[p*32 +: 32];
  end

  assign agg     = src_in & en_q & CONN_MASK & ~FWD_MASK;
  assign fwd_irq = src_in & CONN_MASK & FWD_MASK;

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    assign irq_next[o] = |(agg & MAP_MASK[o*NSRC +: NSRC]);

    // R4 / R8: a rising output needs a live, enabled, wired, non-forwarded cause
    p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out[o]) |-> $past(|(src_in & en_q & CONN_MASK & ~FWD_MASK)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= irq_next;
  end

  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(en_q));

  p_status_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_status) |=> $stable(en_q));

  p_fwd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((src_in & ~FWD_MASK) == $past(src_in & ~FWD_MASK)) && $stable(en_q))
      |=> $stable(irq_out));

  p_fwd_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_irq & ~src_in) == '0);

endmodule

// File: tb/l2_irq_aggregator_bench.sv
module l2_irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src_in = '0;
  logic        bus_we = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_out;
  logic [63:0] fwd_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_irq_aggregator u_l2_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .fwd_irq(fwd_irq));

  typedef struct {
    logic [1:0]  out;
    logic [63:0] fwd;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done  = 0;
  logic [31:0] en0 = 0, en1 = 0;

  localparam logic [31:0] C0 = 32'hFFF, C1 = 32'hFF, F0 = 32'h7;
  localparam logic [31:0] M00 = 32'hEB8, M01 = 32'h0F, M10 = 32'h140, M11 = 32'hF0;

  function automatic exp_t model(logic [63:0] s, string tag);
    exp_t e;
    logic [31:0] a0, a1;
    a0 = s[31:0] & en0 & C0 & ~F0;
    a1 = s[63:32] & en1 & C1;
    e.out[0] = |(a0 & M00) | |(a1 & M01);
    e.out[1] = |(a0 & M10) | |(a1 & M11);
    e.fwd    = {32'h0, s[31:0] & C0 & F0};
    e.tag    = tag;
    return e;
  endfunction

  task automatic check(logic [63:0] act, logic [63:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] s, string tag);
    @(negedge clk);
    src_in = s;
    exp_q.push_back(model(s, tag));
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
    if (a == 4'h0) en0 = d & C0;
    if (a == 4'h8) en1 = d & C1;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    #1 check({32'h0, bus_rdata}, {32'h0, exp}, tag);
  endtask

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check({62'h0, irq_out}, {62'h0, e.out}, {e.tag, " out"});
      check(fwd_irq, e.fwd, {e.tag, " fwd"});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'h0, 32'h0, "R1 en0");
    rd(4'h8, 32'h0, "R1 en1");
    @(negedge clk);
    check({62'h0, irq_out}, 64'h0, "R1 irq_out");
    // R5 nothing enabled
    apply(64'h0000_00FF_0000_0FF8, "R5 all disabled");
    // R2 / R8 whole-word writes, unwired bits stay zero
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0000_0FFF, "R2 R8 en0 readback");
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, 32'h0000_00FF, "R2 R9 en1 readback");
    wr(4'h0, 32'h0000_0A50);
    rd(4'h0, 32'h0000_0A50, "R2 full replace");
    wr(4'h0, 32'hFFFF_FFFF);
    // R3 status
    @(negedge clk); src_in = 64'hFFFF_FF0F_FFFF_F00A;
    rd(4'h4, 32'h0000_000A, "R3 R8 status0");
    rd(4'hC, 32'h0000_000F, "R3 R9 status1");
    wr(4'h4, 32'h0);
    rd(4'h0, 32'h0000_0FFF, "R3 status write ignored");
    // R4 .. R9 via scoreboard
    apply(64'h0, "R4 idle");
    apply(64'h8, "R4 src3 out0");
    apply(64'h40, "R4 src6 out1");
    apply(64'h148, "R4 both");
    apply(64'h7, "R6 R7 forwarded only");
    apply(64'hF, "R6 R7 fwd plus src3");
    apply(64'hFFFF_FF00_FFFF_F000, "R8 unwired high");
    apply(64'h0000_0001_0000_0000, "R9 pair1 out0");
    apply(64'h0000_0010_0000_0000, "R9 pair1 out1");
    apply(64'h0, "R4 drop");
    wr(4'h0, 32'h0000_0040);
    apply(64'h0000_0000_0000_0089, "R5 R6 src3 disabled fwd0 live");
    apply(64'h0000_0000_0000_0040, "R5 src6 enabled");
    wr(4'h8, 32'h0);
    apply(64'h0000_00FF_0000_0000, "R5 pair1 disabled");
    apply(64'h0, "R4 final idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule